// File: doc/BRIEF.md
# SMI Feature Negotiation Controller

This block lets platform firmware agree with the host on a set of system-management features and then uses the outcome to steer system-management interrupts (SMIs). The host side presents a fixed 64-bit mask of the features it supports. Firmware writes a 64-bit request, one byte at a time, through a small register port. It then writes the accepted-flag address. That write checks the request against the host mask and against the dependency rules between features. A request that passes is copied into a negotiated register, and the flag is set. From then on the result is locked until reset.

The block also decodes writes to an 8-bit power-management command port. Two command values only produce a one-cycle pulse on an ACPI-enable or ACPI-disable output. Every other value raises an SMI request, provided the SMI enable input is high. The request goes to all CPUs when broadcast was negotiated. Otherwise it goes only to the CPU that issued the command. The register port and the command port are plain strobes with no back-pressure: each strobe is consumed in the cycle it is seen, so no ready signal exists.

Top module: `smi_negotiator`

## Requirements
- R1: After reset, `accepted_o` is 0, `negotiated_o` is 0, every readable address returns 0, and `smi_req_o`, `acpi_on_o` and `acpi_off_o` are all 0.
- R2: The request is stored little-endian. A write to address k (0 to 7) sets request bits [8k+7:8k]. Reading address k returns those bits. Reading address 8 returns {7'b0, accepted}. Any other address reads 0.
- R3: A write to address 8 with a request holding any bit that is clear in `host_feat_i` leaves `accepted_o` at 0 and `negotiated_o` unchanged.
- R4: A request with bit 1 (hotplug) or bit 2 (hot-unplug) set but bit 0 (broadcast) clear is rejected.
- R5: A request with bit 2 set and bit 1 clear is rejected.
- R6: A write to address 8 with a valid request copies the request into `negotiated_o` and sets `accepted_o`. Both are visible in the cycle after the write. An all-zero request is valid.
- R7: Once `accepted_o` is 1, further writes to address 8 are ignored and `negotiated_o` holds. The request bytes stay writable.
- R8: Reset clears the request, `accepted_o` and `negotiated_o`. The host mask is an input and is not affected by reset.
- R9: Command 0xF0 gives a one-cycle `acpi_on_o` pulse and command 0xF1 gives a one-cycle `acpi_off_o` pulse. Each pulse appears in the cycle after the command. Neither command raises any SMI request.
- R10: Any other command raises no SMI request while `smi_apm_en_i` is 0.
- R11: Any other command with `smi_apm_en_i` high sets, in the next cycle and for one cycle, every bit of `smi_req_o` if negotiated bit 0 is 1. Otherwise it sets only bit `apm_cpu_i`.
- R12: When a command and an accepted-flag write fall in the same cycle, the SMI target choice uses the negotiated value held before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_feat_i | input | 64 | Host-supported feature mask |
| reg_wr_en_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register write address |
| reg_wdata_i | input | 8 | Register write byte |
| reg_rd_addr_i | input | 4 | Register read address |
| reg_rdata_o | output | 8 | Register read byte (combinational) |
| apm_valid_i | input | 1 | Command port write strobe |
| apm_cmd_i | input | 8 | Command value |
| apm_cpu_i | input | 2 | Index of the issuing CPU |
| smi_apm_en_i | input | 1 | SMI enable for commands |
| negotiated_o | output | 64 | Locked negotiated features |
| accepted_o | output | 1 | Negotiation accepted flag |
| acpi_on_o | output | 1 | ACPI-enable pulse |
| acpi_off_o | output | 1 | ACPI-disable pulse |
| smi_req_o | output | 4 | Per-CPU SMI request pulses |

## Verification
Two functions can act in the same cycle: locking in a request, and fanning out an SMI for a command. The bench provokes this by raising the accepted-flag write and a non-ACPI command on the same falling edge. The request is a valid broadcast request that has not yet been accepted. The bench judges the result one cycle later. The flag must now read 1, but the SMI must reach only the issuing CPU, because broadcast was not yet in force. The next command must then reach every CPU.

// File: rtl/smi_neg_pkg.sv
package smi_neg_pkg;
  localparam int unsigned FEAT_BCAST  = 0;
  localparam int unsigned FEAT_HOTADD = 1;
  localparam int unsigned FEAT_HOTDEL = 2;
  localparam logic [7:0]  CMD_ACPI_ON  = 8'hF0;
  localparam logic [7:0]  CMD_ACPI_OFF = 8'hF1;
endpackage

// File: rtl/smi_feat_check.sv
module smi_feat_check
  import smi_neg_pkg::*;
#(
  parameter int FEAT_W = 64
) (
  input  logic [FEAT_W-1:0] req_i,
  input  logic [FEAT_W-1:0] host_i,
  output logic              valid_o
);
  logic unknown_bits;
  logic needs_bcast;
  logic del_without_add;

  always_comb begin
    unknown_bits    = |(req_i & ~host_i);
    needs_bcast     = (req_i[FEAT_HOTADD] | req_i[FEAT_HOTDEL]) & ~req_i[FEAT_BCAST];
    del_without_add = req_i[FEAT_HOTDEL] & ~req_i[FEAT_HOTADD];
    valid_o         = ~(unknown_bits | needs_bcast | del_without_add);
  end
endmodule

// File: rtl/smi_feat_regs.sv
module smi_feat_regs
  import smi_neg_pkg::*;
#(
  parameter int FEAT_W = 64,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FEAT_W-1:0] host_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic [FEAT_W-1:0] negotiated_o,
  output logic              accepted_o
);
  localparam int NBYTES = FEAT_W / 8;
  localparam logic [ADDR_W-1:0] ADDR_FLAG = ADDR_W'(NBYTES);

  logic [7:0]        lane_q [NBYTES];
  logic [FEAT_W-1:0] req_w;
  logic [FEAT_W-1:0] neg_q;
  logic              acc_q;
  logic              req_ok;
  logic              try_lock;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)
        lane_q[b] <= '0;
      else if (wr_en_i && wr_addr_i == ADDR_W'(b))
        lane_q[b] <= wr_data_i;
    end
    assign req_w[b*8 +: 8] = lane_q[b];
  end

  smi_feat_check #(.FEAT_W(FEAT_W)) u_check (
    .req_i   (req_w),
    .host_i  (host_i),
    .valid_o (req_ok)
  );

  assign try_lock = wr_en_i && wr_addr_i == ADDR_FLAG && !acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      neg_q <= '0;
      acc_q <= 1'b0;
    end else if (try_lock && req_ok) begin
      neg_q <= req_w;
      acc_q <= 1'b1;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int b = 0; b < NBYTES; b++)
      if (rd_addr_i == ADDR_W'(b)) rd_data_o = lane_q[b];
    if (rd_addr_i == ADDR_FLAG) rd_data_o = {7'b0, acc_q};
  end

  assign negotiated_o = neg_q;
  assign accepted_o   = acc_q;

  // R7
  acc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q |=> acc_q);
  // R7
  neg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q |=> $stable(neg_q));
  // R3
  neg_in_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_q) |-> (neg_q & ~$past(host_i)) == '0);
  // R5
  del_needs_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q |-> !(neg_q[FEAT_HOTDEL] && !neg_q[FEAT_HOTADD]));
endmodule

// File: rtl/smi_apm_dispatch.sv
module smi_apm_dispatch
  import smi_neg_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic [7:0]       cmd_i,
  input  logic [CPU_W-1:0] cpu_i,
  input  logic             smi_en_i,
  input  logic             bcast_i,
  output logic             acpi_on_o,
  output logic             acpi_off_o,
  output logic [NCPU-1:0]  smi_o
);
  logic            is_on;
  logic            is_off;
  logic            raise;
  logic [NCPU-1:0] smi_d;

  assign is_on  = valid_i && cmd_i == CMD_ACPI_ON;
  assign is_off = valid_i && cmd_i == CMD_ACPI_OFF;
  assign raise  = valid_i && !(cmd_i == CMD_ACPI_ON || cmd_i == CMD_ACPI_OFF) && smi_en_i;

  for (genvar c = 0; c < NCPU; c++) begin : g_target
    assign smi_d[c] = raise && (bcast_i || cpu_i == CPU_W'(c));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acpi_on_o  <= 1'b0;
      acpi_off_o <= 1'b0;
      smi_o      <= '0;
    end else begin
      acpi_on_o  <= is_on;
      acpi_off_o <= is_off;
      smi_o      <= smi_d;
    end
  end

  // R9
  acpi_no_smi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acpi_on_o || acpi_off_o) |-> smi_o == '0);
  // R10
  smi_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smi_en_i |=> smi_o == '0);
  // R11
  single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bcast_i |-> $onehot0(smi_o));
endmodule

// File: rtl/smi_negotiator.sv
module smi_negotiator
  import smi_neg_pkg::*;
#(
  parameter int FEAT_W = 64,
  parameter int ADDR_W = 4,
  parameter int NCPU   = 4,
  parameter int CPU_W  = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FEAT_W-1:0] host_feat_i,
  input  logic              reg_wr_en_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  input  logic [ADDR_W-1:0] reg_rd_addr_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              apm_valid_i,
  input  logic [7:0]        apm_cmd_i,
  input  logic [CPU_W-1:0]  apm_cpu_i,
  input  logic              smi_apm_en_i,
  output logic [FEAT_W-1:0] negotiated_o,
  output logic              accepted_o,
  output logic              acpi_on_o,
  output logic              acpi_off_o,
  output logic [NCPU-1:0]   smi_req_o
);
  logic [FEAT_W-1:0] neg_w;

  smi_feat_regs #(.FEAT_W(FEAT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_i       (host_feat_i),
    .wr_en_i      (reg_wr_en_i),
    .wr_addr_i    (reg_addr_i),
    .wr_data_i    (reg_wdata_i),
    .rd_addr_i    (reg_rd_addr_i),
    .rd_data_o    (reg_rdata_o),
    .negotiated_o (neg_w),
    .accepted_o   (accepted_o)
  );

  smi_apm_dispatch #(.NCPU(NCPU), .CPU_W(CPU_W)) u_disp (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_i    (apm_valid_i),
    .cmd_i      (apm_cmd_i),
    .cpu_i      (apm_cpu_i),
    .smi_en_i   (smi_apm_en_i),
    .bcast_i    (neg_w[FEAT_BCAST]),
    .acpi_on_o  (acpi_on_o),
    .acpi_off_o (acpi_off_o),
    .smi_o      (smi_req_o)
  );

  assign negotiated_o = neg_w;
endmodule

// File: tb/test_smi_negotiator.sv
`timescale 1ns/1ps
module test_smi_negotiator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] host_feat = 64'h17;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        apm_valid = 1'b0;
  logic [7:0]  apm_cmd = '0;
  logic [1:0]  apm_cpu = '0;
  logic        smi_en = 1'b0;
  logic [63:0] neg;
  logic        acc, acpi_on, acpi_off;
  logic [3:0]  smi;
  int ntot = 0, nfail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  smi_negotiator i_smi_negotiator (
    .clk(clk), .rst_n(rst_n), .host_feat_i(host_feat),
    .reg_wr_en_i(wr_en), .reg_addr_i(wr_addr), .reg_wdata_i(wr_data),
    .reg_rd_addr_i(rd_addr), .reg_rdata_o(rd_data),
    .apm_valid_i(apm_valid), .apm_cmd_i(apm_cmd), .apm_cpu_i(apm_cpu),
    .smi_apm_en_i(smi_en), .negotiated_o(neg), .accepted_o(acc),
    .acpi_on_o(acpi_on), .acpi_off_o(acpi_off), .smi_req_o(smi)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    ntot++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    check(act === exp, tag, act, exp);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wr64(input logic [63:0] v);
    for (int b = 0; b < 8; b++) wr(4'(b), v[b*8 +: 8]);
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    rd_addr = a; #0.5; d = rd_data;
  endtask

  task automatic apm(input logic [7:0] c, input logic [1:0] cpu, input bit en);
    @(negedge clk); apm_valid = 1'b1; apm_cmd = c; apm_cpu = cpu; smi_en = en;
    @(negedge clk); apm_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    chk_eq("R1 accepted", acc, 0);
    chk_eq("R1 negotiated", neg, 0);
    for (int a = 0; a < 9; a++) begin rd(4'(a), d); chk_eq("R1 read", d, 0); end
    chk_eq("R1 outputs", {acpi_on, acpi_off, smi}, 0);
  endtask

  task automatic t_bytes();
    logic [7:0] d;
    logic [63:0] v = 64'h0123_4567_89AB_CDEF;
    wr64(v);
    for (int a = 0; a < 8; a++) begin rd(4'(a), d); chk_eq("R2 byte", d, v[a*8 +: 8]); end
    rd(4'd8, d); chk_eq("R2 flag read", d, 0);
    rd(4'd12, d); chk_eq("R2 unused addr", d, 0);
  endtask

  task automatic t_rejects();
    wr64(64'h21); wr(4'd8, 8'h01);
    chk_eq("R3 unknown bit rejected", acc, 0);
    chk_eq("R3 negotiated unchanged", neg, 0);
    wr64(64'h6); wr(4'd8, 8'h01);
    chk_eq("R4 unplug+hotplug no bcast", acc, 0);
    wr64(64'h2); wr(4'd8, 8'h01);
    chk_eq("R4 hotplug no bcast", acc, 0);
    wr64(64'h5); wr(4'd8, 8'h01);
    chk_eq("R5 unplug without hotplug", acc, 0);
    chk_eq("R5 negotiated unchanged", neg, 0);
  endtask

  task automatic t_same_cycle();
    wr64(64'h3);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd8; wr_data = 8'h01;
    apm_valid = 1'b1; apm_cmd = 8'h40; apm_cpu = 2'd2; smi_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; apm_valid = 1'b0;
    chk_eq("R6 accepted", acc, 1);
    chk_eq("R6 negotiated", neg, 64'h3);
    chk_eq("R12 old value steers SMI", smi, 4'b0100);
    @(negedge clk);
    chk_eq("R11 pulse one cycle", smi, 0);
    apm(8'h40, 2'd1, 1'b1);
    chk_eq("R11 broadcast", smi, 4'b1111);
  endtask

  task automatic t_lock();
    logic [7:0] d;
    wr64(64'h1); wr(4'd8, 8'h01);
    chk_eq("R7 still accepted", acc, 1);
    chk_eq("R7 negotiated held", neg, 64'h3);
    rd(4'd0, d); chk_eq("R7 request writable", d, 8'h01);
  endtask

  task automatic t_acpi();
    apm(8'hF0, 2'd0, 1'b1);
    chk_eq("R9 on pulse", {acpi_on, acpi_off, smi}, 6'b100000);
    @(negedge clk);
    chk_eq("R9 on pulse ends", acpi_on, 0);
    apm(8'hF1, 2'd3, 1'b1);
    chk_eq("R9 off pulse", {acpi_on, acpi_off, smi}, 6'b010000);
  endtask

  task automatic t_smi_off();
    apm(8'h40, 2'd0, 1'b0);
    chk_eq("R10 disabled", smi, 0);
  endtask

  task automatic t_reset_again();
    logic [7:0] d;
    do_reset();
    chk_eq("R8 accepted cleared", acc, 0);
    chk_eq("R8 negotiated cleared", neg, 0);
    rd(4'd0, d); chk_eq("R8 request cleared", d, 0);
    wr(4'd8, 8'h01);
    chk_eq("R6 empty request accepted", acc, 1);
    apm(8'h40, 2'd3, 1'b1);
    chk_eq("R11 single target", smi, 4'b1000);
    do_reset();
    wr64(64'h17); wr(4'd8, 8'h01);
    chk_eq("R6 full host set", neg, 64'h17);
    chk_eq("R6 full host accepted", acc, 1);
  endtask

  initial begin
    t_reset();
    t_bytes();
    t_rejects();
    t_same_cycle();
    t_lock();
    t_acpi();
    t_smi_off();
    t_reset_again();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", ntot - nfail, ntot);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      ntot++; nfail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", ntot - nfail, ntot);
      $finish;
    end
  end
endmodule